// File: doc/BRIEF.md
# Tearing-Effect Frame Start Trigger

This block decides the cycle in which a frame transfer to a panel may begin. A start request either fires at once (internal trigger) or arms the block. An armed block then waits for the panel's tearing-effect pin. In the vsync-only mode, the first active pulse fires the trigger. In the line mode, a single pin carries both hsync and vsync pulses. The block tells them apart by measuring each pulse in clock ticks against two programmed widths. It counts hsync lines from the latest vsync and fires when the count reaches a programmed line.

The output is a one-cycle `go` pulse to the transfer engine. The block carries no pixel stream, so every pin is a plain control or status pin. There is no valid/ready pair and no back-pressure. A request made while the block is already armed is dropped. A tearing-effect pulse seen while the block is not armed has no effect. The pin passes through a two-stage synchronizer. The active level of each sync type has its own polarity bit (1 = active low).

Top module: `te_frame_trigger`

## Requirements
- R1: After reset `go` is low, and the block is not armed until a start request arrives.
- R2: With `trig_mode` = 0 (internal) and `te_en` = 1, a start request sampled at a clock edge makes `go` high for exactly the following cycle.
- R3: With `te_en` = 0, a start request behaves as in R2 whatever `trig_mode` holds.
- R4: With `trig_mode` = 1 (vsync only), an armed block makes `go` high in the third cycle after the pin reaches its active level. The active level is high when `vs_invert` = 0 and low when `vs_invert` = 1.
- R5: In line mode, a pulse whose active length in clock ticks is at least `vs_width` counts as a vsync and clears the line count. When `line_target` = 0, `go` is high in the third cycle after that pulse ends.
- R6: In line mode, a pulse whose length is at least `hs_width` and below `vs_width` counts as an hsync and adds one to the line count. `go` is high in the third cycle after the hsync that brings the count equal to `line_target`. The hsync active level follows `hs_invert` in the same way as R4.
- R7: A pulse shorter than `hs_width` changes neither the line count nor `go`. A pulse of exactly `vs_width - 1` ticks counts as an hsync.
- R8: After arming, hsync pulses are not counted until the first vsync has been seen.
- R9: Each start request yields at most one `go` pulse. Pulses on the pin while the block is not armed have no effect. A start request while armed is ignored and does not restart the line search.
- R10: `trig_mode` = 3 behaves exactly as `trig_mode` = 2 (line mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_pin | input | 1 | Tearing-effect pin from the panel, asynchronous |
| start_req | input | 1 | Frame start request, one cycle |
| te_en | input | 1 | 1 = wait for tearing sync, 0 = trigger at once |
| trig_mode | input | 2 | 0 internal, 1 vsync only, 2 or 3 line mode |
| vs_invert | input | 1 | Vsync active level, 1 = active low |
| hs_invert | input | 1 | Hsync active level, 1 = active low |
| vs_width | input | CNT_W | Minimum vsync length in clock ticks |
| hs_width | input | CNT_W | Minimum hsync length in clock ticks |
| line_target | input | LINE_W | Line on which to fire in line mode |
| go | output | 1 | One-cycle transfer start pulse |

## Verification
The hardest cases to reach from the ports are the line-mode corners. These are an hsync that arrives after arming but before any vsync, a request repeated while armed, and pulse lengths that sit exactly on the `hs_width` and `vs_width` thresholds. To reach them, the stimulus arms the block and then drives pulse trains of exact tick lengths in a chosen order. Each test has one correct firing cycle. Counting a premature hsync, restarting on a second request, or misclassifying a boundary pulse shifts `go` to a different cycle, and the scoreboard reports the mismatch.

// File: rtl/te_trig_pkg.sv
package te_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_INTERNAL  = 2'd0,
    TRIG_VSYNC     = 2'd1,
    TRIG_LINE      = 2'd2,
    TRIG_LINE_ALT  = 2'd3
  } trig_mode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } trig_state_e;

  localparam int unsigned METER_VS = 0;
  localparam int unsigned METER_HS = 1;
  localparam int unsigned N_METERS = 2;

endpackage

// File: rtl/te_pin_sync.sv
module te_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], pin_async};
  end

  assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             invert,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] width
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active;
  logic             active_q;
  logic [CNT_W-1:0] ticks;

  assign active = level ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ticks    <= '0;
    end else begin
      active_q <= active;
      if (!active)               ticks <= '0;
      else if (ticks != CNT_MAX) ticks <= ticks + 1'b1;
    end
  end

  assign rise  = active & ~active_q;
  assign fall  = ~active & active_q;
  assign width = ticks;

endmodule

// File: rtl/te_trig_ctrl.sv
module te_trig_ctrl
  import te_trig_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              te_en,
  input  logic [1:0]        trig_mode,
  input  logic [LINE_W-1:0] line_target,
  input  logic [CNT_W-1:0]  vs_width,
  input  logic [CNT_W-1:0]  hs_width,
  input  logic              vs_rise,
  input  logic              vs_fall,
  input  logic [CNT_W-1:0]  vs_w,
  input  logic              hs_fall,
  input  logic [CNT_W-1:0]  hs_w,
  output logic              go,
  output logic              armed
);

  trig_state_e       state;
  trig_mode_e        mode;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] line_next;
  logic              frame_seen;
  logic              line_mode;
  logic              is_vsync;
  logic              is_hsync;

  assign mode      = trig_mode_e'(trig_mode);
  assign line_mode = (mode == TRIG_LINE) || (mode == TRIG_LINE_ALT);
  assign is_vsync  = vs_fall && (vs_w >= vs_width);
  assign is_hsync  = hs_fall && (hs_w >= hs_width) && (hs_w < vs_width);
  assign line_next = line_cnt + LINE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      go         <= 1'b0;
      line_cnt   <= '0;
      frame_seen <= 1'b0;
    end else begin
      go <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            if (!te_en || mode == TRIG_INTERNAL) begin
              go <= 1'b1;
            end else begin
              state      <= ST_ARMED;
              frame_seen <= 1'b0;
              line_cnt   <= '0;
            end
          end
        end
        ST_ARMED: begin
          if (!line_mode) begin
            if (vs_rise) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (is_vsync) begin
            frame_seen <= 1'b1;
            line_cnt   <= '0;
            if (line_target == '0) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (is_hsync && frame_seen) begin
            line_cnt <= line_next;
            if (line_next == line_target) begin
              go    <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign armed = (state == ST_ARMED);

endmodule

// File: rtl/te_frame_trigger.sv
module te_frame_trigger
  import te_trig_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_pin,
  input  logic              start_req,
  input  logic              te_en,
  input  logic [1:0]        trig_mode,
  input  logic              vs_invert,
  input  logic              hs_invert,
  input  logic [CNT_W-1:0]  vs_width,
  input  logic [CNT_W-1:0]  hs_width,
  input  logic [LINE_W-1:0] line_target,
  output logic              go
);

  logic                  pin_s;
  logic [N_METERS-1:0]   inv_v;
  logic [N_METERS-1:0]   rise_v;
  logic [N_METERS-1:0]   fall_v;
  logic [CNT_W-1:0]      width_v [N_METERS];

  logic                  vs_rise;
  logic                  vs_fall;
  logic [CNT_W-1:0]      vs_w;
  logic                  hs_fall;
  logic [CNT_W-1:0]      hs_w;
  logic                  armed;
  logic                  unused_hs_rise;

  te_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(te_pin),
    .pin_sync (pin_s)
  );

  assign inv_v[METER_VS] = vs_invert;
  assign inv_v[METER_HS] = hs_invert;

  for (genvar i = 0; i < N_METERS; i++) begin : g_meter
    te_pulse_meter #(.CNT_W(CNT_W)) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pin_s),
      .invert(inv_v[i]),
      .rise  (rise_v[i]),
      .fall  (fall_v[i]),
      .width (width_v[i])
    );
  end

  assign vs_rise        = rise_v[METER_VS];
  assign vs_fall        = fall_v[METER_VS];
  assign vs_w           = width_v[METER_VS];
  assign hs_fall        = fall_v[METER_HS];
  assign hs_w           = width_v[METER_HS];
  assign unused_hs_rise = rise_v[METER_HS];

  te_trig_ctrl #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .te_en      (te_en),
    .trig_mode  (trig_mode),
    .line_target(line_target),
    .vs_width   (vs_width),
    .hs_width   (hs_width),
    .vs_rise    (vs_rise),
    .vs_fall    (vs_fall),
    .vs_w       (vs_w),
    .hs_fall    (hs_fall),
    .hs_w       (hs_w),
    .go         (go),
    .armed      (armed)
  );

endmodule

// File: rtl/te_frame_trigger_chk.sv
module te_frame_trigger_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_req,
  input logic              te_en,
  input logic [1:0]        trig_mode,
  input logic [LINE_W-1:0] line_target,
  input logic [CNT_W-1:0]  vs_width,
  input logic [CNT_W-1:0]  hs_width,
  input logic              go,
  input logic              armed,
  input logic              vs_rise,
  input logic              vs_fall,
  input logic [CNT_W-1:0]  vs_w,
  input logic              hs_fall,
  input logic [CNT_W-1:0]  hs_w
);

  a_r2_internal_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && start_req && te_en && trig_mode == 2'd0) |=> go);

  a_r3_sync_off_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && start_req && !te_en) |=> go);

  a_r4_vsync_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_mode == 2'd1 && vs_rise) |=> go);

  a_r5_vsync_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_mode[1] && vs_fall && vs_w >= vs_width && line_target == '0) |=> go);

  a_r7_short_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_mode[1] && hs_fall && hs_w < hs_width
     && !(vs_fall && vs_w >= vs_width)) |=> !go);

  a_r9_no_unrequested_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_req) |=> !go);

  a_r9_go_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !armed);

endmodule

bind te_frame_trigger te_frame_trigger_chk #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .te_en      (te_en),
  .trig_mode  (trig_mode),
  .line_target(line_target),
  .vs_width   (vs_width),
  .hs_width   (hs_width),
  .go         (go),
  .armed      (armed),
  .vs_rise    (vs_rise),
  .vs_fall    (vs_fall),
  .vs_w       (vs_w),
  .hs_fall    (hs_fall),
  .hs_w       (hs_w)
);

// File: tb/sim_te_frame_trigger.sv
`timescale 1ns/1ps
module sim_te_frame_trigger;

  localparam int unsigned CW = 8;
  localparam int unsigned LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          te_pin = 1'b0;
  logic          start_req = 1'b0;
  logic          te_en = 1'b1;
  logic [1:0]    trig_mode = 2'd2;
  logic          vs_invert = 1'b0;
  logic          hs_invert = 1'b0;
  logic [CW-1:0] vs_width = 8'd6;
  logic [CW-1:0] hs_width = 8'd2;
  logic [LW-1:0] line_target = 11'd3;
  logic          go;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic  act_lvl = 1'b1;
  int    exp_cyc[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  te_frame_trigger u0 (
    .clk(clk), .rst_n(rst_n), .te_pin(te_pin), .start_req(start_req),
    .te_en(te_en), .trig_mode(trig_mode), .vs_invert(vs_invert),
    .hs_invert(hs_invert), .vs_width(vs_width), .hs_width(hs_width),
    .line_target(line_target), .go(go)
  );

  // Monitor: compare every go pulse against the scoreboard queue
  always @(negedge clk) begin
    int    e;
    string t;
    if (rst_n && go) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        errors++;
        $display("FAIL R9: go at cycle %0d, actual 1 expected 0", cyc);
      end else begin
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (cyc != e) begin
          errors++;
          $display("FAIL %s: go at cycle %0d, expected cycle %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic expect_go(int c, string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(bit immediate, string tag);
    @(negedge clk);
    start_req = 1'b1;
    if (immediate) expect_go(cyc + 1, tag);
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic te_pulse(int k, bit on_rise, bit on_end, string tag);
    int c;
    @(negedge clk);
    te_pin = act_lvl;
    c = cyc;
    if (on_rise) expect_go(c + 3, tag);
    repeat (k) @(negedge clk);
    te_pin = ~act_lvl;
    if (on_end) expect_go(c + k + 3, tag);
    idle(6);
  endtask

  task automatic drain(string tag);
    idle(8);
    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL %s: go pulses seen 0, expected %0d more", tag, exp_cyc.size());
      exp_cyc.delete();
      exp_tag.delete();
    end
  endtask

  task automatic set_polarity(bit inv);
    @(negedge clk);
    vs_invert = inv;
    hs_invert = inv;
    act_lvl   = ~inv;
    te_pin    = inv;
    idle(6);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (go !== 1'b0) begin
      errors++;
      $display("FAIL R1: go after reset actual %b expected 0", go);
    end

    // R1/R9: pulses without any request do nothing
    te_pulse(8, 0, 0, "R9");
    te_pulse(3, 0, 0, "R9");
    drain("R1");

    // R2: internal trigger, then TE pulses ignored
    trig_mode = 2'd0;
    request(1, "R2");
    te_pulse(8, 0, 0, "R9");
    drain("R2");

    // R3: sync disabled overrides line mode
    trig_mode = 2'd2;
    te_en     = 1'b0;
    request(1, "R3");
    drain("R3");
    te_en = 1'b1;

    // R4: vsync-only, active high, second pulse ignored
    trig_mode = 2'd1;
    request(0, "R4");
    idle(2);
    te_pulse(3, 1, 0, "R4");
    te_pulse(3, 0, 0, "R9");
    drain("R4");

    // R4: vsync-only, active low
    set_polarity(1'b1);
    request(0, "R4");
    idle(2);
    te_pulse(2, 1, 0, "R4");
    drain("R4");

    // R6: line mode, both inverted, target 3
    trig_mode   = 2'd2;
    line_target = 11'd3;
    request(0, "R6");
    te_pulse(8, 0, 0, "R6");
    te_pulse(3, 0, 0, "R6");
    te_pulse(3, 0, 0, "R6");
    te_pulse(3, 0, 1, "R6");
    te_pulse(3, 0, 0, "R9");
    drain("R6");
    set_polarity(1'b0);

    // R5: vsync of exactly vs_width with target 0
    line_target = 11'd0;
    request(0, "R5");
    te_pulse(6, 0, 1, "R5");
    drain("R5");

    // R8: hsyncs before the first vsync are not counted
    line_target = 11'd1;
    request(0, "R8");
    te_pulse(3, 0, 0, "R8");
    te_pulse(3, 0, 0, "R8");
    te_pulse(7, 0, 0, "R8");
    te_pulse(2, 0, 1, "R8");
    drain("R8");

    // R7: glitch ignored, vs_width-1 counts as hsync
    request(0, "R7");
    te_pulse(8, 0, 0, "R7");
    te_pulse(1, 0, 0, "R7");
    te_pulse(5, 0, 1, "R7");
    drain("R7");

    // R10: mode 3 behaves as line mode
    trig_mode   = 2'd3;
    line_target = 11'd2;
    request(0, "R10");
    te_pulse(9, 0, 0, "R10");
    te_pulse(4, 0, 0, "R10");
    te_pulse(4, 0, 1, "R10");
    drain("R10");

    // R9: second request while armed must not restart the search
    trig_mode   = 2'd2;
    line_target = 11'd1;
    request(0, "R9");
    te_pulse(8, 0, 0, "R9");
    request(0, "R9");
    te_pulse(3, 0, 1, "R9");
    drain("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule